// File: doc/BRIEF.md
# Nine-Line Shared-Pin LED Digit Scanner

This block scans up to eight seven-segment digits, each with a decimal point, over nine shared I/O lines. Each line has its own drive-enable and drive-value. A line can sink the common cathode of one digit, source one segment of that digit, or float. Only one digit is lit at any time. Its cathode sits on the line whose index equals the digit number. Its eight segment bits occupy the other eight lines, so the line that carries each segment moves as the active digit moves. The pad ring turns each enable/value pair into a tristate driver. Current limiting and brightness are handled outside the block.

The scanner takes the active digit's segment byte from an outside register file. It does this by presenting the digit index on `rd_idx` and reading the byte back on `rd_byte` in the same cycle. The byte is used as raw segment bits with no character decoding. Each pulse of `tick_en` moves the display on to the next digit, and the scanner puts a one-cycle blank between digits. A scan-limit register sets the highest digit index. It resets to 4, which scans digits 0 to 4, and `limit_we` loads a new value. The `shutdown` input stops the scan and floats every line.

The controller has four states. ST_WAIT floats all lines and waits for a tick. ST_SHOW drives the current digit. ST_GAP is the single blank cycle between digits. ST_OFF is shutdown. The transitions are:
- WAIT→SHOW on a tick.
- SHOW→GAP on a tick, which also advances the digit index or wraps it to 0.
- GAP→SHOW always, after one cycle.
- OFF→WAIT when `shutdown` falls, which also clears the index to 0.
- Any state→OFF whenever `shutdown` is high. This takes priority over every other transition.

Reset enters ST_WAIT at digit 0.

Top module: `led_scan_top`

## Requirements
- R1: After reset all nine `line_oe` bits are 0, `rd_idx` is 0, and the lines stay released until the first `tick_en`.
- R2: While digit k is shown, line k has `line_oe`=1 and `line_val`=0, and it is the only line driven low.
- R3: While digit k is shown, segment bit 7,6,...,0 of `rd_byte` (dp,g,f,e,d,c,b,a) goes to lines 0 to 8 in ascending order, skipping line k.
- R4: A segment line whose bit is 1 has `line_oe`=1 and `line_val`=1. A segment line whose bit is 0 has `line_oe`=0.
- R5: On every change of the shown digit, the scanner holds exactly one clock cycle with all `line_oe` bits at 0 before the next digit is driven.
- R6: Out of reset the scan limit is 4, so the digits shown are 0,1,2,3,4, then 0 again.
- R7: A cycle with `limit_we`=1 loads `limit_in` as the highest digit index. Limit 7 scans all eight digits, and limit 0 keeps showing digit 0 with a blank cycle on each tick.
- R8: One cycle after `shutdown` is high, all `line_oe` bits are 0. Ticks have no effect while it stays high.
- R9: While no `tick_en` arrives, the shown digit and its line drive stay unchanged.
- R10: Line 8 is never driven low.
- R11: If the limit is lowered below the shown digit, the next tick wraps the scan to digit 0.
- R12: When `shutdown` falls, the scan restarts at digit 0 and waits, released, for a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse that advances the scan |
| shutdown | input | 1 | Stop scan and float all lines |
| limit_we | input | 1 | Load `limit_in` into the scan-limit register |
| limit_in | input | 3 | New highest digit index |
| rd_idx | output | 3 | Register-file read index, equal to the current digit |
| rd_byte | input | 8 | Segment byte of digit `rd_idx` (bit 7 dp ... bit 0 a) |
| line_oe | output | 9 | Per-line drive enable |
| line_val | output | 9 | Per-line drive level when enabled |

## Verification
The hardest case to reach is a scan limit lowered under the digit on display. It needs the scan to be advanced well past the new limit before the write lands. The stimulus first programs limit 7 and ticks up to digit 6. It then writes limit 2 and checks that the next tick passes through the blank cycle to digit 0 and not to digit 7. Shutdown is asserted mid-scan with ticks still arriving, to show that the index neither moves nor resumes anywhere but at 0.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    // Segment bits per digit: dp plus seven bars.
    localparam int SEG_W     = 8;
    // One line per segment plus the one extra segment-only line.
    localparam int LINE_CNT  = SEG_W + 1;
    // Digit index width, enough for SEG_W digits.
    localparam int DIG_IDX_W = $clog2(SEG_W);

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_SHOW = 2'd1,
        ST_GAP  = 2'd2,
        ST_OFF  = 2'd3
    } scan_state_e;

endpackage

// File: rtl/led_scan_cfg.sv
module led_scan_cfg
    import led_scan_pkg::*;
#(
    parameter int NUM_DIGITS  = 8,
    parameter int RESET_LIMIT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 limit_we,
    input  logic [DIG_IDX_W-1:0] limit_in,
    output logic [DIG_IDX_W-1:0] limit_q
);

    localparam logic [DIG_IDX_W-1:0] MAX_IDX   = DIG_IDX_W'(NUM_DIGITS - 1);
    localparam logic [DIG_IDX_W-1:0] RST_VALUE = DIG_IDX_W'(RESET_LIMIT);

    logic [DIG_IDX_W-1:0] clamped;

    // A limit beyond the wired digits is pulled back to the last one.
    always_comb begin
        if (limit_in > MAX_IDX) begin
            clamped = MAX_IDX;
        end else begin
            clamped = limit_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= RST_VALUE;
        end else if (limit_we) begin
            limit_q <= clamped;
        end
    end

endmodule

// File: rtl/led_scan_fsm.sv
module led_scan_fsm
    import led_scan_pkg::*;
#(
    parameter int NUM_DIGITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 shutdown,
    input  logic [DIG_IDX_W-1:0] limit_q,
    output scan_state_e          state_q,
    output logic [DIG_IDX_W-1:0] digit_q
);

    scan_state_e          state_d;
    logic [DIG_IDX_W-1:0] digit_d;
    logic [DIG_IDX_W-1:0] digit_next;

    // Wrap when at or beyond the limit, so a lowered limit takes effect.
    always_comb begin
        if (digit_q >= limit_q) begin
            digit_next = '0;
        end else begin
            digit_next = digit_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        digit_d = digit_q;
        unique case (state_q)
            ST_WAIT: begin
                if (tick_en) begin
                    state_d = ST_SHOW;
                end
            end
            ST_SHOW: begin
                if (tick_en) begin
                    state_d = ST_GAP;
                    digit_d = digit_next;
                end
            end
            ST_GAP: begin
                state_d = ST_SHOW;
            end
            ST_OFF: begin
                digit_d = '0;
                if (!shutdown) begin
                    state_d = ST_WAIT;
                end
            end
            default: begin
                state_d = ST_WAIT;
                digit_d = '0;
            end
        endcase
        if (shutdown) begin
            state_d = ST_OFF;
            digit_d = (state_q == ST_OFF) ? '0 : digit_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            digit_q <= '0;
        end else begin
            state_q <= state_d;
            digit_q <= digit_d;
        end
    end

endmodule

// File: rtl/led_scan_router.sv
module led_scan_router
    import led_scan_pkg::*;
#(
    parameter int NUM_DIGITS = 8
) (
    input  logic                 active,
    input  logic [DIG_IDX_W-1:0] digit,
    input  logic [SEG_W-1:0]     seg_byte,
    output logic [LINE_CNT-1:0]  oe,
    output logic [LINE_CNT-1:0]  val
);

    for (genvar ln = 0; ln < LINE_CNT; ln++) begin : g_line
        // Segment slot this line carries when it lies below or above the cathode.
        localparam int BIT_BELOW = (ln < SEG_W) ? (SEG_W - 1 - ln) : 0;
        localparam int BIT_ABOVE = (ln > 0) ? (SEG_W - ln) : 0;

        logic is_cath;
        logic below;
        logic seg_on;

        if (ln < NUM_DIGITS) begin : g_dual
            assign is_cath = (digit == DIG_IDX_W'(ln));
        end else begin : g_seg_only
            assign is_cath = 1'b0;
        end

        assign below  = (32'(digit) > ln);
        assign seg_on = below ? seg_byte[BIT_BELOW] : seg_byte[BIT_ABOVE];

        always_comb begin
            oe[ln]  = 1'b0;
            val[ln] = 1'b0;
            if (active) begin
                if (is_cath) begin
                    oe[ln]  = 1'b1;
                    val[ln] = 1'b0;
                end else if (seg_on) begin
                    oe[ln]  = 1'b1;
                    val[ln] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/led_scan_top.sv
module led_scan_top
    import led_scan_pkg::*;
#(
    parameter int NUM_DIGITS  = 8,
    parameter int RESET_LIMIT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 shutdown,
    input  logic                 limit_we,
    input  logic [DIG_IDX_W-1:0] limit_in,
    output logic [DIG_IDX_W-1:0] rd_idx,
    input  logic [SEG_W-1:0]     rd_byte,
    output logic [LINE_CNT-1:0]  line_oe,
    output logic [LINE_CNT-1:0]  line_val
);

    scan_state_e          state_q;
    logic [DIG_IDX_W-1:0] digit_q;
    logic [DIG_IDX_W-1:0] limit_q;
    logic                 show;
    logic [LINE_CNT-1:0]  rt_oe;
    logic [LINE_CNT-1:0]  rt_val;

    led_scan_cfg #(
        .NUM_DIGITS  (NUM_DIGITS),
        .RESET_LIMIT (RESET_LIMIT)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .limit_we (limit_we),
        .limit_in (limit_in),
        .limit_q  (limit_q)
    );

    led_scan_fsm #(
        .NUM_DIGITS (NUM_DIGITS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .shutdown (shutdown),
        .limit_q  (limit_q),
        .state_q  (state_q),
        .digit_q  (digit_q)
    );

    assign show   = (state_q == ST_SHOW);
    assign rd_idx = digit_q;

    led_scan_router #(
        .NUM_DIGITS (NUM_DIGITS)
    ) u_router (
        .active   (show),
        .digit    (digit_q),
        .seg_byte (rd_byte),
        .oe       (rt_oe),
        .val      (rt_val)
    );

    // Output process: only the show state lets the router reach the pins.
    always_comb begin
        unique case (state_q)
            ST_SHOW: begin
                line_oe  = rt_oe;
                line_val = rt_val;
            end
            default: begin
                line_oe  = '0;
                line_val = '0;
            end
        endcase
    end

endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk
    import led_scan_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_en,
    input logic                 shutdown,
    input logic [DIG_IDX_W-1:0] rd_idx,
    input logic [LINE_CNT-1:0]  line_oe,
    input logic [LINE_CNT-1:0]  line_val
);

    // R2
    cathode_on_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_oe) |-> (line_oe[rd_idx] && !line_val[rd_idx]));

    // R2
    single_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_oe) |-> ($countones(line_oe & ~line_val) == 1));

    // R5
    blank_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx != $past(rd_idx)) |-> (line_oe == '0));

    // R8
    shutdown_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (line_oe == '0));

    // R9
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|line_oe) && !tick_en && !shutdown) |=> (rd_idx == $past(rd_idx)));

    // R10
    line8_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe[LINE_CNT-1] |-> line_val[LINE_CNT-1]);

endmodule

bind led_scan_top led_scan_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .shutdown (shutdown),
    .rd_idx   (rd_idx),
    .line_oe  (line_oe),
    .line_val (line_val)
);

// File: tb/led_scan_top_tb.sv
module led_scan_top_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_en;
    logic       shutdown;
    logic       limit_we;
    logic [2:0] limit_in;
    logic [2:0] rd_idx;
    logic [7:0] rd_byte;
    logic [8:0] line_oe;
    logic [8:0] line_val;

    logic [7:0] regs [8];
    int         n_chk = 0;
    int         n_err = 0;

    localparam logic [7:0] PAT [8] = '{8'hFF, 8'h00, 8'h80, 8'h01,
                                       8'hA5, 8'h5A, 8'h3C, 8'hC3};

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rd_byte = regs[rd_idx];

    led_scan_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .shutdown (shutdown),
        .limit_we (limit_we),
        .limit_in (limit_in),
        .rd_idx   (rd_idx),
        .rd_byte  (rd_byte),
        .line_oe  (line_oe),
        .line_val (line_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Segment s (0=dp .. 7=a) takes line s, or s+1 once the cathode is passed.
    task automatic show_chk(input int k, input string req);
        logic [8:0] eo;
        logic [8:0] ev;
        eo = '0;
        ev = '0;
        eo[k] = 1'b1;
        for (int s = 0; s < 8; s++) begin
            int ln;
            ln = (s < k) ? s : s + 1;
            if (regs[k][7 - s]) begin
                eo[ln] = 1'b1;
                ev[ln] = 1'b1;
            end
        end
        chk({req, " idx"}, 32'(rd_idx), 32'(k));
        chk({req, " oe"}, 32'(line_oe), 32'(eo));
        chk({req, " val"}, 32'(line_val & line_oe), 32'(ev));
        chk("R10 line8", 32'(line_oe[8] & ~line_val[8]), 32'd0);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick();
        tick_en = 1'b1;
        step();
        tick_en = 1'b0;
    endtask

    // Tick from a shown digit: one blank cycle, then the next digit.
    task automatic advance(input int nxt, input string req);
        tick();
        chk("R5 gap blank", 32'(line_oe), 32'd0);
        chk({req, " gap idx"}, 32'(rd_idx), 32'(nxt));
        step();
        show_chk(nxt, req);
    endtask

    task automatic set_limit(input int lim);
        limit_we = 1'b1;
        limit_in = 3'(lim);
        step();
        limit_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = PAT[i];
        rst_n    = 1'b0;
        tick_en  = 1'b0;
        shutdown = 1'b0;
        limit_we = 1'b0;
        limit_in = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state and idle without ticks
        chk("R1 reset oe", 32'(line_oe), 32'd0);
        chk("R1 reset idx", 32'(rd_idx), 32'd0);
        repeat (4) step();
        chk("R1 idle oe", 32'(line_oe), 32'd0);

        // R2 R3 R4 first digit
        tick();
        show_chk(0, "R2 R3 R4 first");

        // R6 default five-digit scan
        for (int i = 1; i <= 4; i++) advance(i, "R6 default");
        advance(0, "R6 wrap");

        // R7 table walk over all eight digits
        set_limit(7);
        for (int i = 1; i < 8; i++) advance(i, "R7 R3 table");
        advance(0, "R7 wrap7");

        // R9 hold without ticks
        repeat (5) step();
        show_chk(0, "R9 hold");

        // R11 lowered limit
        for (int i = 1; i <= 6; i++) advance(i, "R11 climb");
        set_limit(2);
        show_chk(6, "R11 before");
        advance(0, "R11 wrap");
        advance(1, "R11 next");

        // R7 limit 0
        set_limit(0);
        advance(0, "R7 lim0");
        advance(0, "R7 lim0 again");

        // R4 live change of raw data
        regs[0] = 8'h01;
        @(negedge clk);
        show_chk(0, "R4 raw a only");
        chk("R4 line8 a", 32'(line_oe[8]), 32'd1);

        // R8 shutdown mid-scan with ticks
        set_limit(7);
        advance(1, "R8 pre");
        shutdown = 1'b1;
        step();
        chk("R8 off oe", 32'(line_oe), 32'd0);
        tick();
        tick();
        chk("R8 ticks ignored", 32'(line_oe), 32'd0);

        // R12 resume at digit 0 waiting for a tick
        shutdown = 1'b0;
        step();
        chk("R12 wait idx", 32'(rd_idx), 32'd0);
        chk("R12 wait oe", 32'(line_oe), 32'd0);
        step();
        chk("R12 still wait", 32'(line_oe), 32'd0);
        tick();
        show_chk(0, "R12 resume");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule